// File: doc/BRIEF.md
# Tick-to-Microsecond Scaler

This block turns an elapsed count of timer ticks into microseconds. The timer's input clock rate in hertz and the prescale divisor applied to it are known. Before it can convert, the block derives a scale factor that holds microseconds per tick with sixteen fractional bits. The same sequential restoring divider is used twice for this. The first pass takes the clock rate in kilohertz, truncated. The second pass divides the scaled divisor by that kilohertz value, with half the kilohertz value added to the numerator so that the quotient rounds to nearest.

Once a factor exists, each tick count presented with a valid strobe runs through a two-stage pipeline. The first stage multiplies the count by the factor at full width. The second stage adds a small rounding bias and drops the sixteen fractional bits. Setup uses a start/done handshake and reports an error flag. Conversion uses a valid-in/valid-out path, and the block takes conversion requests only while a factor is held and no setup is running.

Top module: `tick_usec_conv`

## Requirements
- R1: While and after reset, cfg_done, cfg_err, cfg_busy, conv_ready and us_valid are 0 and factor_q16 is 0.
- R2: A setup with cfg_freq_hz >= 1000 sets factor_q16 to ((65536000 * cfg_divisor) + K/2) / K, where K = cfg_freq_hz / 1000 and both divisions truncate.
- R3: For each accepted tick count T, us_value equals (T * factor_q16 + 4096) >> 16. The product is held at full width (48 bits), so no count from 0 to 65535 overflows for any factor.
- R4: A tick_valid accepted in cycle c gives us_valid = 1 in cycle c+2. Back-to-back inputs give back-to-back outputs in order, and us_valid is 0 in every cycle that has no matching input.
- R5: While conv_ready is 0, a tick_valid yields no us_valid. conv_ready is 0 from reset until the first successful setup, and 0 throughout every running setup.
- R6: A setup with cfg_freq_hz < 1000 pulses cfg_done one cycle after start, with cfg_err = 1. factor_q16 and conv_ready keep their previous values.
- R7: cfg_done is a single-cycle pulse. For a valid rate it arrives no later than 2*NUM_W+6 cycles after start (72 with defaults). cfg_busy is 1 from the cycle after start until cfg_done.
- R8: A cfg_start while cfg_busy is 1 is ignored. The running setup finishes with its own operands, and no second cfg_done follows.
- R9: cfg_err holds until the next accepted setup and is 0 after a successful one. factor_q16 changes only in a cycle where cfg_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Begin a setup, sampled while idle |
| cfg_freq_hz | input | 32 | Timer input clock rate in Hz |
| cfg_divisor | input | 6 | Prescale divisor of the timer clock |
| cfg_done | output | 1 | One-cycle pulse at the end of a setup |
| cfg_err | output | 1 | Last setup was refused (rate below 1000 Hz) |
| cfg_busy | output | 1 | Setup in progress |
| conv_ready | output | 1 | Conversion requests are being taken |
| factor_q16 | output | 32 | Current scale factor, unsigned Q16 |
| tick_valid | input | 1 | Tick count present |
| tick_count | input | 16 | Elapsed ticks to convert |
| us_valid | output | 1 | Converted result present |
| us_value | output | 32 | Microseconds, rounded |

## Verification
The bound checker watches several rules on every cycle: the done pulse lasts one cycle, the ready/busy exclusion holds, every output has an accepted input two cycles earlier, the factor changes only when done is high, and a refused setup leaves ready unchanged. The numeric rules can only be shown by the bench's scenarios, which predict values from the formulas. These are the truncated-then-rounded division of the factor, the bias-and-shift rounding at large counts and at the 1000 Hz edge, the ignoring of a start during a running setup, and the clearing of the error flag.

// File: rtl/tick_usec_pkg.sv
// Package: widths and shared types of the tick-to-microsecond scaler.
// Assumes: a divisor of at most DIV_W bits keeps the rounded Q16 factor
// within FACTOR_W bits for any rate of at least 1000 Hz.
package tick_usec_pkg;
    localparam int FREQ_W    = 32;
    localparam int DIV_W     = 6;
    localparam int TICK_W    = 16;
    localparam int FACTOR_W  = 32;
    localparam int FRAC_W    = 16;
    localparam int RND_POS   = 12;
    localparam int HZ_PER_KHZ = 1000;
    localparam int PROD_W    = TICK_W + FACTOR_W;
    localparam int US_W      = PROD_W - FRAC_W;
    localparam int SCALE_W   = $clog2((64'd1000 << FRAC_W) + 64'd1);
    localparam int NUM_W     = SCALE_W + DIV_W + 1;
    localparam int DV_N_W    = (NUM_W > FREQ_W) ? NUM_W : FREQ_W;
    localparam int DV_D_W    = FREQ_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_KHZ   = 2'd1,
        ST_RATIO = 2'd2
    } setup_state_e;
endpackage

// File: rtl/tick_usec_seq_div.sv
// Restoring unsigned divider, one quotient bit per clock.
// What: after a start pulse it loads dividend and divisor, runs N_W
// iterations and pulses done with the quotient valid from then on.
// Assumes: divisor is non-zero and held by the caller until done.
module tick_usec_seq_div #(
    parameter int N_W = 33,
    parameter int D_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           done,
    output logic [N_W-1:0] quotient
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [N_W-1:0]   q_sh;
    logic [D_W-1:0]   rem;
    logic [CNT_W-1:0] iter_left;
    logic             running;
    logic [D_W:0]     rem_sh;
    logic [D_W+1:0]   trial;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        rem_sh = {rem, q_sh[N_W-1]};
        trial  = {1'b0, rem_sh} - {2'b00, divisor};
        fits   = ~trial[D_W+1];
    end

    // Iteration state: shift one quotient bit in per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sh      <= '0;
            rem       <= '0;
            iter_left <= '0;
            running   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_sh      <= dividend;
                rem       <= '0;
                iter_left <= CNT_W'(N_W);
                running   <= 1'b1;
            end else if (running) begin
                q_sh      <= {q_sh[N_W-2:0], fits};
                rem       <= fits ? D_W'(trial) : D_W'(rem_sh);
                iter_left <= iter_left - 1'b1;
                if (iter_left == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign quotient = q_sh;
endmodule

// File: rtl/tick_usec_ratio_ctrl.sv
// Setup sequencer for the Q16 microseconds-per-tick factor.
// What: checks the rate, runs the shared divider twice (rate/1000, then
// the rounded scaled divisor over that), and commits the factor.
// Assumes: start is sampled only while idle; a low rate refuses the setup.
module tick_usec_ratio_ctrl
    import tick_usec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FREQ_W-1:0]   freq_hz,
    input  logic [DIV_W-1:0]    divisor,
    output logic                done,
    output logic                err,
    output logic                busy,
    output logic                have_factor,
    output logic [FACTOR_W-1:0] factor
);
    localparam logic [DV_N_W-1:0] SCALE_Q16 = DV_N_W'(64'd1000 << FRAC_W);
    localparam logic [FREQ_W-1:0] MIN_HZ    = FREQ_W'(HZ_PER_KHZ);

    setup_state_e        state;
    logic                dv_start;
    logic                dv_done;
    logic [DV_N_W-1:0]   dv_num;
    logic [DV_D_W-1:0]   dv_den;
    logic [DV_N_W-1:0]   dv_quot;
    logic [DIV_W-1:0]    div_hold;
    logic [DV_D_W-1:0]   khz_w;
    logic [DV_N_W-1:0]   ratio_num;

    // Second-pass numerator: scaled divisor plus half the kHz value.
    always_comb begin
        khz_w     = DV_D_W'(dv_quot);
        ratio_num = SCALE_Q16 * DV_N_W'(div_hold) + DV_N_W'(khz_w >> 1);
    end

    // Sequencer: refuse, then kHz pass, then ratio pass, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            dv_start    <= 1'b0;
            dv_num      <= '0;
            dv_den      <= '0;
            div_hold    <= '0;
            done        <= 1'b0;
            err         <= 1'b0;
            have_factor <= 1'b0;
            factor      <= '0;
        end else begin
            dv_start <= 1'b0;
            done     <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (freq_hz < MIN_HZ) begin
                            err  <= 1'b1;
                            done <= 1'b1;
                        end else begin
                            err      <= 1'b0;
                            div_hold <= divisor;
                            dv_num   <= DV_N_W'(freq_hz);
                            dv_den   <= DV_D_W'(HZ_PER_KHZ);
                            dv_start <= 1'b1;
                            state    <= ST_KHZ;
                        end
                    end
                end
                ST_KHZ: begin
                    if (dv_done) begin
                        dv_num   <= ratio_num;
                        dv_den   <= khz_w;
                        dv_start <= 1'b1;
                        state    <= ST_RATIO;
                    end
                end
                ST_RATIO: begin
                    if (dv_done) begin
                        factor      <= FACTOR_W'(dv_quot);
                        have_factor <= 1'b1;
                        done        <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    tick_usec_seq_div #(
        .N_W (DV_N_W),
        .D_W (DV_D_W)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dv_start),
        .dividend (dv_num),
        .divisor  (dv_den),
        .done     (dv_done),
        .quotient (dv_quot)
    );
endmodule

// File: rtl/tick_usec_conv_pipe.sv
// Two-stage conversion pipeline: full-width multiply, then bias and shift.
// Assumes: in_valid is already gated by readiness; factor is steady while
// requests are accepted.
module tick_usec_conv_pipe
    import tick_usec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [TICK_W-1:0]   ticks,
    input  logic [FACTOR_W-1:0] factor,
    output logic                out_valid,
    output logic [US_W-1:0]     out_us
);
    localparam logic [PROD_W:0] BIAS = (PROD_W+1)'(1) << RND_POS;

    logic              s1_valid;
    logic [PROD_W-1:0] s1_prod;
    logic [PROD_W:0]   biased;

    // Rounding sum, one bit wider than the product.
    always_comb begin
        biased = {1'b0, s1_prod} + BIAS;
    end

    // Stage 1: register the exact product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_prod <= PROD_W'(ticks) * PROD_W'(factor);
            end
        end
    end

    // Stage 2: register the rounded microsecond value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_us    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_us <= US_W'(biased >> FRAC_W);
            end
        end
    end
endmodule

// File: rtl/tick_usec_conv.sv
// Top of the tick-to-microsecond scaler.
// What: joins the setup sequencer and the conversion pipeline and gates
// conversion requests on a held factor and an idle sequencer.
// Assumes: a single clock domain and synchronous active-low reset.
module tick_usec_conv
    import tick_usec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_start,
    input  logic [FREQ_W-1:0]   cfg_freq_hz,
    input  logic [DIV_W-1:0]    cfg_divisor,
    output logic                cfg_done,
    output logic                cfg_err,
    output logic                cfg_busy,
    output logic                conv_ready,
    output logic [FACTOR_W-1:0] factor_q16,
    input  logic                tick_valid,
    input  logic [TICK_W-1:0]   tick_count,
    output logic                us_valid,
    output logic [US_W-1:0]     us_value
);
    logic have_factor;
    logic accept;

    // Request gating: only with a committed factor and no setup running.
    always_comb begin
        conv_ready = have_factor & ~cfg_busy;
        accept     = tick_valid & conv_ready;
    end

    tick_usec_ratio_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cfg_start),
        .freq_hz     (cfg_freq_hz),
        .divisor     (cfg_divisor),
        .done        (cfg_done),
        .err         (cfg_err),
        .busy        (cfg_busy),
        .have_factor (have_factor),
        .factor      (factor_q16)
    );

    tick_usec_conv_pipe pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (accept),
        .ticks     (tick_count),
        .factor    (factor_q16),
        .out_valid (us_valid),
        .out_us    (us_value)
    );
endmodule

// File: rtl/tick_usec_conv_chk.sv
// Checker for the tick-to-microsecond scaler, bound to the top module.
// Assumes: reset is held for at least one clock edge at start-up.
module tick_usec_conv_chk
    import tick_usec_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_start,
    input logic                cfg_done,
    input logic                cfg_err,
    input logic                cfg_busy,
    input logic                conv_ready,
    input logic [FACTOR_W-1:0] factor_q16,
    input logic                tick_valid,
    input logic                us_valid
);
    // R7: done never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);

    // R5: no conversion is taken during a setup
    p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> !conv_ready);

    // R4: every output stems from an accepted input two cycles before
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        us_valid |-> $past(tick_valid && conv_ready, 2));

    // R9: the factor moves only together with done
    p_factor_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(factor_q16) |-> cfg_done);

    // R6: a refused setup leaves readiness unchanged
    p_refuse_keeps_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_err) |-> $stable(conv_ready));

    // R6: the error flag rises only with done
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> cfg_done);
endmodule

bind tick_usec_conv tick_usec_conv_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .cfg_done   (cfg_done),
    .cfg_err    (cfg_err),
    .cfg_busy   (cfg_busy),
    .conv_ready (conv_ready),
    .factor_q16 (factor_q16),
    .tick_valid (tick_valid),
    .us_valid   (us_valid)
);

// File: tb/tick_usec_conv_tb_top.sv
// Directed bench for the tick-to-microsecond scaler.
module tick_usec_conv_tb_top;
    import tick_usec_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_start = 1'b0;
    logic [FREQ_W-1:0]   cfg_freq_hz = '0;
    logic [DIV_W-1:0]    cfg_divisor = '0;
    logic                cfg_done;
    logic                cfg_err;
    logic                cfg_busy;
    logic                conv_ready;
    logic [FACTOR_W-1:0] factor_q16;
    logic                tick_valid = 1'b0;
    logic [TICK_W-1:0]   tick_count = '0;
    logic                us_valid;
    logic [US_W-1:0]     us_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tick_usec_conv dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
        .cfg_freq_hz(cfg_freq_hz), .cfg_divisor(cfg_divisor),
        .cfg_done(cfg_done), .cfg_err(cfg_err), .cfg_busy(cfg_busy),
        .conv_ready(conv_ready), .factor_q16(factor_q16),
        .tick_valid(tick_valid), .tick_count(tick_count),
        .us_valid(us_valid), .us_value(us_value)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_factor(input longint hz, input longint dv);
        longint khz = hz / 1000;
        return (65536000 * dv + (khz >> 1)) / khz;
    endfunction

    function automatic longint exp_us(input longint t, input longint f);
        return (t * f + 4096) >> 16;
    endfunction

    // Runs one setup; returns the number of cycles until done is seen.
    task automatic run_setup(input longint hz, input int dv, input bit tick_during,
                             output int took);
        bit saw_out = 1'b0;
        @(negedge clk);
        cfg_start = 1'b1; cfg_freq_hz = FREQ_W'(hz); cfg_divisor = DIV_W'(dv);
        @(negedge clk);
        cfg_start = 1'b0;
        tick_valid = tick_during; tick_count = 16'd500;
        took = 1;
        while (!cfg_done && took < 200) begin
            if (us_valid) saw_out = 1'b1;
            @(negedge clk);
            took++;
        end
        tick_valid = 1'b0;
        if (tick_during) check("R5 no output during setup", saw_out, 0);
    endtask

    task automatic t_reset();
        check("R1 done", cfg_done, 0);
        check("R1 err", cfg_err, 0);
        check("R1 busy", cfg_busy, 0);
        check("R1 ready", conv_ready, 0);
        check("R1 us_valid", us_valid, 0);
        check("R1 factor", factor_q16, 0);
    endtask

    task automatic t_ignored_before_setup();
        bit seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            tick_valid = 1'b1; tick_count = 16'(100 + i);
            if (us_valid) seen = 1'b1;
        end
        @(negedge clk); tick_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (us_valid) seen = 1'b1;
            @(negedge clk);
        end
        check("R5 ignored before first setup", seen, 0);
    endtask

    task automatic t_setup_ok(input longint hz, input int dv);
        int took;
        run_setup(hz, dv, 1'b1, took);
        check("R7 done arrives in time", (took <= 2*NUM_W+6 && took >= 2) ? 1 : 0, 1);
        check("R2 factor value", factor_q16, exp_factor(hz, dv));
        check("R9 err clear after success", cfg_err, 0);
        check("R5 ready after setup", conv_ready, 1);
        @(negedge clk);
        check("R7 done single pulse", cfg_done, 0);
    endtask

    // Streams counts back to back and checks each result two cycles later.
    task automatic t_stream(input longint t0, input longint t1, input longint t2,
                            input longint t3);
        longint ts[4];
        longint f = longint'(factor_q16);
        ts[0] = t0; ts[1] = t1; ts[2] = t2; ts[3] = t3;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R4 us_valid in cycle c+2", us_valid, 1);
                check("R3 rounded value", us_value, exp_us(ts[i-2], f));
            end else begin
                check("R4 no output without input", us_valid, 0);
            end
            tick_valid = (i < 4);
            tick_count = (i < 4) ? 16'(ts[i]) : '0;
        end
        @(negedge clk);
        check("R4 us_valid low after stream", us_valid, 0);
    endtask

    task automatic t_bad_freq();
        longint old_f = longint'(factor_q16);
        logic old_ready = conv_ready;
        int took;
        run_setup(999, 3, 1'b0, took);
        check("R6 done one cycle after start", took, 1);
        check("R6 err set", cfg_err, 1);
        check("R6 factor kept", factor_q16, old_f);
        check("R6 ready kept", conv_ready, old_ready);
        @(negedge clk);
        check("R9 err held", cfg_err, 1);
    endtask

    task automatic t_start_while_busy();
        int took = 0;
        int dones = 0;
        @(negedge clk);
        cfg_start = 1'b1; cfg_freq_hz = 32'd12000000; cfg_divisor = 6'd1;
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (5) @(negedge clk);
        cfg_start = 1'b1; cfg_freq_hz = 32'd66000000; cfg_divisor = 6'd6;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int i = 0; i < 2*NUM_W + 20; i++) begin
            if (cfg_done) dones++;
            @(negedge clk);
        end
        check("R8 single done", dones, 1);
        check("R8 first operands kept", factor_q16, exp_factor(12000000, 1));
        check("R8 idle afterwards", cfg_busy, 0);
        took = took;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignored_before_setup();
        t_setup_ok(12000000, 1);
        t_stream(0, 1, 12000, 65535);
        t_setup_ok(50700000, 6);
        t_stream(8450, 65535, 3, 40000);
        t_bad_freq();
        t_stream(1000, 2000, 30000, 7);
        t_setup_ok(1000, 63);
        t_stream(65535, 1, 65534, 0);
        t_setup_ok(1999, 1);
        t_stream(3, 65535, 1, 2);
        t_start_while_busy();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 100000 && !finished) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule